// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Register Access

This block is a timer peripheral. At its core is an up-counter that advances on ticks chosen from one of two sources. Both sources are single-cycle tick-enable strobes sampled in the bus clock domain. The peripheral strobe feeds the main divider directly. The oscillator strobe first passes through a small divider of its own and then reaches the main divider. Software configures the timer through a word-addressed register port. It selects the source, sets the two divide ratios, starts the count and reads the current value back.

In free-run mode the counter wraps from all ones to zero. Otherwise it returns to zero on the tick that follows a match with the first compare register. The other compare registers, the capture registers and the interrupt-enable word are plain storage. A self-clearing software-reset bit returns the whole block to its reset state. That bit stays visible while the internal reset sequence runs, so software can poll it.

Top module: `gp_timer`

## Requirements
- R1: Word addresses are laid out as follows: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare 0 to 2, 7 and 8 capture 0 and 1, 9 counter. After reset every address reads zero. Addresses 3 to 8 store all 32 written bits. Control keeps only bits 0 and 6 to 10. Prescaler keeps only bits 15:0.
- R2: The counter advances only while control bit 0 (enable) is 1. Source ticks that arrive while the bit is 0 leave the counter unchanged.
- R3: When control bit 9 is 1, the counter wraps from its maximum value to zero.
- R4: When control bit 9 is 0, a counter tick that finds the counter equal to compare 0 loads zero instead of incrementing.
- R5: Control bits 8:6 select the source. Code 1 takes the peripheral tick and code 5 takes the oscillator tick. Any other code, and any tick from the source that is not selected, leaves the counter unchanged.
- R6: Oscillator ticks have no effect unless control bit 10 is 1.
- R7: With the peripheral source, the counter advances once every N+1 ticks, where N is prescaler bits 11:0.
- R8: With the oscillator source, ticks are divided first by M+1 and then by N+1, where M is prescaler bits 15:12. The count after t ticks is floor(floor(t/(M+1))/(N+1)).
- R9: Writing 1 to control bit 15 clears the counter and every register. Bit 15 then reads 1 for 4 cycles and returns to 0 by itself. Writes made during those cycles are ignored.
- R10: The counter address is read-only. Writes to it are ignored, and reading it changes nothing.
- R11: A write to the prescaler restarts both divider phases, so the next full divide period starts with the following tick.
- R12: Status always reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, with req_i |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| per_tick_i | input | 1 | Peripheral source tick enable |
| osc_tick_i | input | 1 | Oscillator source tick enable |

## Verification
Every fault in the divider phases, the source gating or the counter update appears as a counter value that differs from the arithmetic expectation. A read taken directly after each tick exposes it on the first tick that should, or should not, have advanced the count. A fault in the reset sequence appears on the control read within one cycle of the write, either as a bit 15 that clears too early or too late, or as a register that is not cleared. A stale divider phase after a prescaler write shows up one tick early, on the first period after the write.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned AW    = 4;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_PRE  = 4'd1;
  localparam logic [AW-1:0] A_STAT = 4'd2;
  localparam logic [AW-1:0] A_IEN  = 4'd3;
  localparam logic [AW-1:0] A_CMP0 = 4'd4;
  localparam logic [AW-1:0] A_CMP1 = 4'd5;
  localparam logic [AW-1:0] A_CMP2 = 4'd6;
  localparam logic [AW-1:0] A_CAP0 = 4'd7;
  localparam logic [AW-1:0] A_CAP1 = 4'd8;
  localparam logic [AW-1:0] A_CNT  = 4'd9;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_SRC  = 6;
  localparam int unsigned B_FREE = 9;
  localparam int unsigned B_OSC  = 10;
  localparam int unsigned B_SRST = 15;

  localparam logic [2:0] SRC_PER = 3'd1;
  localparam logic [2:0] SRC_OSC = 3'd5;

  localparam logic [REG_W-1:0] CTRL_MASK = 32'h0000_07C1;
endpackage

// File: rtl/gpt_div.sv
module gpt_div #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] phase_q;
  logic         wrap;

  assign wrap   = (phase_q == div_i);
  assign tick_o = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clr_i)   phase_q <= '0;
    else if (tick_i)  phase_q <= wrap ? '0 : phase_q + W'(1);
  end

  // phase never passes the divide value, or a period would be lost
  assert_phase_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= div_i);
  assert_clr_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          free_i,
  input  logic [CW-1:0] cmp_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (!free_i && cnt_q == cmp_i) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CW'(1) || cnt_q == '0));
  assert_no_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned N_W         = 12,
  parameter int unsigned M_W         = 4,
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             per_tick_i,
  input  logic             osc_tick_i
);
  localparam int unsigned SW = $clog2(SRST_CYCLES + 1);
  localparam int unsigned PW = N_W + M_W;
  localparam logic [REG_W-1:0] PRE_MASK = REG_W'((64'd1 << PW) - 64'd1);

  logic [REG_W-1:0] ctrl_q, pre_q, ien_q;
  logic [REG_W-1:0] cmp_q [3];
  logic [REG_W-1:0] cap_q [2];
  logic [SW-1:0]    srst_q;
  logic             busy, wr_ok, srst_go, pre_wr;
  logic [2:0]       src;
  logic             osc_in, osc_out, main_in, main_out;
  logic [CNT_W-1:0] cnt;

  assign busy    = (srst_q != '0);
  assign wr_ok   = req_i && we_i && !busy;
  assign srst_go = wr_ok && addr_i == A_CTRL && wdata_i[B_SRST];
  assign pre_wr  = wr_ok && addr_i == A_PRE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; pre_q <= '0; ien_q <= '0; srst_q <= '0;
      for (int i = 0; i < 3; i++) cmp_q[i] <= '0;
      for (int i = 0; i < 2; i++) cap_q[i] <= '0;
    end else if (srst_go) begin
      ctrl_q <= '0; pre_q <= '0; ien_q <= '0;
      srst_q <= SW'(SRST_CYCLES);
      for (int i = 0; i < 3; i++) cmp_q[i] <= '0;
      for (int i = 0; i < 2; i++) cap_q[i] <= '0;
    end else if (busy) begin
      srst_q <= srst_q - SW'(1);
    end else if (wr_ok) begin
      unique case (addr_i)
        A_CTRL: ctrl_q   <= wdata_i & CTRL_MASK;
        A_PRE:  pre_q    <= wdata_i & PRE_MASK;
        A_IEN:  ien_q    <= wdata_i;
        A_CMP0: cmp_q[0] <= wdata_i;
        A_CMP1: cmp_q[1] <= wdata_i;
        A_CMP2: cmp_q[2] <= wdata_i;
        A_CAP0: cap_q[0] <= wdata_i;
        A_CAP1: cap_q[1] <= wdata_i;
        default: ;
      endcase
    end
  end

  // tick path: source select -> oscillator divider -> main divider -> counter
  assign src     = ctrl_q[B_SRC +: 3];
  assign osc_in  = ctrl_q[B_EN] && ctrl_q[B_OSC] && src == SRC_OSC && osc_tick_i;
  assign main_in = (ctrl_q[B_EN] && src == SRC_PER && per_tick_i) || osc_out;

  gpt_div #(.W(M_W)) u_osc_div (
    .clk_i, .rst_ni,
    .clr_i  (srst_go || busy || pre_wr),
    .tick_i (osc_in),
    .div_i  (pre_q[N_W +: M_W]),
    .tick_o (osc_out)
  );

  gpt_div #(.W(N_W)) u_main_div (
    .clk_i, .rst_ni,
    .clr_i  (srst_go || busy || pre_wr),
    .tick_i (main_in),
    .div_i  (pre_q[N_W-1:0]),
    .tick_o (main_out)
  );

  gpt_counter #(.CW(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i  (srst_go || busy),
    .tick_i (main_out),
    .free_i (ctrl_q[B_FREE]),
    .cmp_i  (cmp_q[0][CNT_W-1:0]),
    .cnt_o  (cnt)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q | (REG_W'(busy) << B_SRST);
      A_PRE:   rdata_o = pre_q;
      A_IEN:   rdata_o = ien_q;
      A_CMP0:  rdata_o = cmp_q[0];
      A_CMP1:  rdata_o = cmp_q[1];
      A_CMP2:  rdata_o = cmp_q[2];
      A_CAP0:  rdata_o = cap_q[0];
      A_CAP1:  rdata_o = cap_q[1];
      A_CNT:   rdata_o = REG_W'(cnt);
      default: rdata_o = '0;
    endcase
  end

  assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[B_EN] && !srst_go) |=> $stable(cnt));
  assert_srst_countdown_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (srst_q == $past(srst_q) - SW'(1)));
  assert_osc_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[B_OSC] |-> !osc_out);
  assert_src_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src != SRC_PER && src != SRC_OSC) |-> !main_out);
endmodule

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        per_tick_i = 1'b0, osc_tick_i = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  gp_timer #(.CNT_W(8)) u_gp_timer (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .per_tick_i, .osc_tick_i
  );

  localparam logic [31:0] EN = 32'h1, FREE = 32'h200, OSC = 32'h400;
  localparam logic [31:0] S_PER = 32'h40, S_OSC = 32'h140, S_RES = 32'hC0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic per_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); per_tick_i = 1; @(negedge clk); per_tick_i = 0;
    end
  endtask

  task automatic osc_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick_i = 1; @(negedge clk); osc_tick_i = 0;
    end
  endtask

  task automatic srst();
    wr(4'd0, 32'h8000);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk); rst_ni = 1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin rd(4'(a), v); check("R1 reset", v, 0); end
    // R1 storage
    for (int a = 3; a < 9; a++) wr(4'(a), 32'hA5C3_0000 | 32'(a));
    for (int a = 3; a < 9; a++) begin rd(4'(a), v); check("R1 store", v, 32'hA5C3_0000 | 32'(a)); end
    wr(4'd0, 32'hFFFF_7FFE); rd(4'd0, v); check("R1 ctrl mask", v, 32'h7C0);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); check("R1 pre mask", v, 32'hFFFF);
    // R12 status
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); check("R12 status", v, 0);

    // R9 software reset sequence
    wr(4'd0, 32'h8000);
    for (int i = 0; i < 4; i++) begin rd(4'd0, v); check("R9 busy", v, 32'h8000); @(negedge clk); end
    rd(4'd0, v); check("R9 cleared", v, 0);
    for (int a = 1; a < 10; a++) begin rd(4'(a), v); check("R9 regs zero", v, 0); end
    wr(4'd0, 32'h8000); wr(4'd4, 32'h77);
    repeat (5) @(negedge clk);
    rd(4'd4, v); check("R9 write ignored", v, 0);

    // R7 peripheral divide sweep
    for (int n = 0; n < 4; n++) begin
      srst(); wr(4'd1, 32'(n)); wr(4'd0, EN | FREE | S_PER);
      for (int t = 1; t <= 3 * (n + 1); t++) begin
        per_ticks(1); rd(4'd9, v); check("R7 per div", v, 32'(t / (n + 1)));
      end
    end

    // R8 oscillator two-stage sweep
    for (int m = 0; m < 3; m++)
      for (int n = 0; n < 3; n++) begin
        srst(); wr(4'd1, 32'((m << 12) | n)); wr(4'd0, EN | FREE | OSC | S_OSC);
        for (int t = 1; t <= 2 * (m + 1) * (n + 1); t++) begin
          osc_ticks(1); rd(4'd9, v); check("R8 osc div", v, 32'((t / (m + 1)) / (n + 1)));
        end
      end

    // R6 oscillator path disabled
    srst(); wr(4'd0, EN | FREE | S_OSC);
    osc_ticks(4); rd(4'd9, v); check("R6 osc off", v, 0);
    // R5 wrong source / reserved code
    per_ticks(3); rd(4'd9, v); check("R5 per on osc sel", v, 0);
    wr(4'd0, EN | FREE | OSC | S_RES);
    per_ticks(3); osc_ticks(3); rd(4'd9, v); check("R5 reserved code", v, 0);
    wr(4'd0, EN | FREE | OSC | S_PER);
    osc_ticks(3); rd(4'd9, v); check("R5 osc on per sel", v, 0);

    // R2 enable gating
    srst(); wr(4'd0, FREE | S_PER);
    per_ticks(3); rd(4'd9, v); check("R2 disabled", v, 0);
    wr(4'd0, EN | FREE | S_PER);
    per_ticks(1); rd(4'd9, v); check("R2 enabled", v, 1);

    // R10 counter read-only
    wr(4'd9, 32'h12); rd(4'd9, v); check("R10 write ignored", v, 1);
    rd(4'd9, v); check("R10 reread", v, 1);

    // R3 free-run wrap (8-bit counter)
    srst(); wr(4'd0, EN | FREE | S_PER);
    per_ticks(255); rd(4'd9, v); check("R3 max", v, 255);
    per_ticks(1);   rd(4'd9, v); check("R3 wrap", v, 0);

    // R4 restart on compare 0
    srst(); wr(4'd4, 32'd5); wr(4'd0, EN | S_PER);
    for (int t = 1; t <= 13; t++) begin
      per_ticks(1); rd(4'd9, v); check("R4 restart", v, 32'(t % 6));
    end

    // R11 prescaler write restarts phase
    srst(); wr(4'd1, 32'd3); wr(4'd0, EN | FREE | S_PER);
    per_ticks(2); wr(4'd1, 32'd3);
    per_ticks(3); rd(4'd9, v); check("R11 phase cleared", v, 0);
    per_ticks(1); rd(4'd9, v); check("R11 first period", v, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule